// File: doc/BRIEF.md
# Memory Card Sector Command Responder

This block is the card side of a byte-exchange serial link. The host sends one byte per exchange and takes back one byte in the same exchange. The responder therefore prepares the byte for the next exchange as soon as the current one completes. A frame runs while the select input is high. It opens with an address byte, then a command byte. Two sector-number bytes follow, and then either a 128-byte sector read or a 128-byte sector write. Fixed marker bytes, an echo of the sector number and an XOR checksum are placed among these bytes, so that the host can confirm where it is in the frame.

The sector store sits in a synchronous byte RAM that can be mapped to block RAM. A write goes into a spare slot. A small remap table swaps that slot in only when the frame ends with a good status. A failed or aborted write therefore leaves the old sector in place. A flag byte tells the host whether the card is fresh. After each accepted exchange the responder pulses an active-low acknowledge, except after the closing status byte.

Top module: `mc_responder`

## Requirements
- R1: After reset, `resp_byte` is 0xFF, `ack_n` is high and the card is fresh.
- R2: A frame is accepted only if its first byte is 0x81. For any other first byte, every exchange until select drops returns 0xFF and gets no acknowledge.
- R3: The second exchange returns the flag byte. Only 0x52 (read) and 0x57 (write) continue the frame. Any other command gets no acknowledge, and the rest of the frame returns 0xFF.
- R4: While the host sends the sector high byte and then the sector low byte, the responder returns 0x5A and then 0x5D.
- R5: A read frame then returns, in order: 0x5C, 0x5D, the sector high byte, the sector low byte, the 128 stored bytes, the checksum and 0x47.
- R6: The read checksum is the XOR of the two sector bytes and the 128 data bytes.
- R7: A write frame returns 0x00 while the host sends the 128 data bytes and the checksum, and then returns 0x5C and 0x5D.
- R8: The final byte of a write frame is a status byte. It is 0xFF when bits 7:2 of the sector high byte are not all zero; this check takes precedence. Otherwise it is 0x4E when the host checksum differs from the XOR of the sector bytes and the data. Otherwise it is 0x47. The sector is stored only on 0x47.
- R9: The flag byte is 0x0C (bits 3 and 2 set) while the card is fresh and 0x00 after the first write that ends with 0x47. Failed writes leave it unchanged.
- R10: If select goes low at any point, the frame is abandoned. `resp_byte` is 0xFF one cycle later and no data is stored.
- R11: Each accepted exchange drives `ack_n` low for ACK_LEN cycles, starting the cycle after the strobe. The exchange that carries the final read or write status byte gets no acknowledge.
- R12: Sectors are selected by the low log2(SECTORS) bits of the sector low byte. A read returns the data of the last successful write to that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Card select, high for the length of a frame |
| xfer | input | 1 | One-cycle strobe marking a completed byte exchange |
| host_byte | input | 8 | Byte sent by the host in this exchange |
| resp_byte | output | 8 | Byte the card returns in the next exchange |
| ack_n | output | 1 | Active-low acknowledge pulse |

## Verification
The assertions assume that a strobe arrives only while select is high, and that two strobes are never closer together than the acknowledge pulse plus three cycles. Under that spacing the one-cycle RAM read lands in `resp_byte` before the next exchange, and a pulse always ends before the next one starts. The stimulus gives every exchange a full acknowledge window plus margin, raises select a cycle before the first byte, and lowers it only between exchanges. It mixes random sectors and data with directed bad-address, bad-command, out-of-range, corrupted-checksum and aborted frames.

// File: rtl/mc_resp_pkg.sv
package mc_resp_pkg;
  localparam logic [7:0] ADDR_BYTE = 8'h81;
  localparam logic [7:0] CMD_RD    = 8'h52;
  localparam logic [7:0] CMD_WR    = 8'h57;
  localparam logic [7:0] MK_ACK1   = 8'h5A;
  localparam logic [7:0] MK_ACK2   = 8'h5D;
  localparam logic [7:0] MK_GO     = 8'h5C;
  localparam logic [7:0] END_OK    = 8'h47;
  localparam logic [7:0] END_BADCS = 8'h4E;
  localparam logic [7:0] END_RANGE = 8'hFF;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam logic [7:0] FLAG_NEW  = 8'h0C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SKIP, ST_CMD, ST_SEC_HI, ST_SEC_LO, ST_RD, ST_WR, ST_DONE
  } state_t;
endpackage

// File: rtl/mc_byte_ram.sv
module mc_byte_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mc_slot_map.sv
module mc_slot_map #(
  parameter int SECTORS = 4,
  parameter int SECW    = 2,
  parameter int SLOTW   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SECW-1:0]  idx,
  input  logic             commit,
  output logic [SLOTW-1:0] slot,
  output logic [SLOTW-1:0] spare
);
  logic [SLOTW-1:0] tbl [SECTORS];
  logic [SLOTW-1:0] spare_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SECTORS; i++) tbl[i] <= SLOTW'(i);
      spare_q <= SLOTW'(SECTORS);
    end else if (commit) begin
      tbl[idx] <= spare_q;
      spare_q  <= tbl[idx];
    end
  end

  assign slot  = tbl[idx];
  assign spare = spare_q;
endmodule

// File: rtl/mc_ack_gen.sv
module mc_ack_gen #(
  parameter int ACK_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic ack_n
);
  localparam int CNTW = $clog2(ACK_LEN + 1);
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ack_n <= 1'b1;
    end else if (fire) begin
      cnt   <= CNTW'(ACK_LEN - 1);
      ack_n <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      ack_n <= 1'b1;
    end
  end
endmodule

// File: rtl/mc_responder.sv
module mc_responder
  import mc_resp_pkg::*;
#(
  parameter int SECTORS = 4,
  parameter int BLK     = 128,
  parameter int ACK_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       xfer,
  input  logic [7:0] host_byte,
  output logic [7:0] resp_byte,
  output logic       ack_n
);
  localparam int SECW   = $clog2(SECTORS);
  localparam int PSLOTS = SECTORS + 1;
  localparam int SLOTW  = $clog2(PSLOTS);
  localparam int BW     = $clog2(BLK);
  localparam int AW     = SLOTW + BW;
  localparam int CW     = $clog2(BLK + 8);

  state_t           st;
  logic [CW-1:0]    cnt;
  logic [7:0]       sec_hi, sec_lo, chk, status_q;
  logic             fresh_q, load_pend, take, ack_fire, commit;
  logic [SLOTW-1:0] map_slot, spare_slot;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [7:0]       ram_q;
  logic [BW-1:0]    rd_idx;

  assign take      = xfer & sel;
  assign rd_idx    = cnt[BW-1:0] - BW'(3);
  assign ram_raddr = {map_slot, rd_idx};
  assign ram_waddr = {spare_slot, cnt[BW-1:0]};
  assign ram_we    = take && (st == ST_WR) && (cnt < CW'(BLK));
  assign commit    = take && (st == ST_WR) && (cnt == CW'(BLK + 3))
                     && (status_q == END_OK);

  mc_byte_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(host_byte),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  mc_slot_map #(.SECTORS(SECTORS), .SECW(SECW), .SLOTW(SLOTW)) u_map (
    .clk(clk), .rst(rst), .idx(sec_lo[SECW-1:0]), .commit(commit),
    .slot(map_slot), .spare(spare_slot)
  );

  mc_ack_gen #(.ACK_LEN(ACK_LEN)) u_ack (
    .clk(clk), .rst(rst), .fire(ack_fire), .ack_n(ack_n)
  );

  always_comb begin
    case (st)
      ST_IDLE:              ack_fire = (host_byte == ADDR_BYTE);
      ST_CMD:               ack_fire = (host_byte == CMD_RD) || (host_byte == CMD_WR);
      ST_SEC_HI, ST_SEC_LO: ack_fire = 1'b1;
      ST_RD:                ack_fire = (cnt != CW'(BLK + 5));
      ST_WR:                ack_fire = (cnt != CW'(BLK + 3));
      default:              ack_fire = 1'b0;
    endcase
    ack_fire = ack_fire & take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sec_hi    <= '0;
      sec_lo    <= '0;
      chk       <= '0;
      status_q  <= END_OK;
      fresh_q   <= 1'b1;
      load_pend <= 1'b0;
      resp_byte <= IDLE_BYTE;
    end else if (!sel) begin
      st        <= ST_IDLE;
      load_pend <= 1'b0;
      resp_byte <= IDLE_BYTE;
    end else begin
      load_pend <= 1'b0;
      if (load_pend) begin
        resp_byte <= ram_q;
        chk       <= chk ^ ram_q;
      end
      if (take) begin
        case (st)
          ST_IDLE: begin
            if (host_byte == ADDR_BYTE) begin
              st        <= ST_CMD;
              resp_byte <= fresh_q ? FLAG_NEW : 8'h00;
            end else begin
              st        <= ST_SKIP;
              resp_byte <= IDLE_BYTE;
            end
          end
          ST_CMD: begin
            if (host_byte == CMD_RD || host_byte == CMD_WR) begin
              st        <= ST_SEC_HI;
              resp_byte <= MK_ACK1;
            end else begin
              st        <= ST_SKIP;
              resp_byte <= IDLE_BYTE;
            end
            status_q <= (host_byte == CMD_WR) ? END_BADCS : END_OK;
          end
          ST_SEC_HI: begin
            sec_hi    <= host_byte;
            resp_byte <= MK_ACK2;
            st        <= ST_SEC_LO;
          end
          ST_SEC_LO: begin
            sec_lo    <= host_byte;
            chk       <= sec_hi ^ host_byte;
            cnt       <= '0;
            st        <= (status_q == END_BADCS) ? ST_WR : ST_RD;
            resp_byte <= (status_q == END_BADCS) ? 8'h00 : MK_GO;
          end
          ST_RD: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(0))                resp_byte <= MK_ACK2;
            else if (cnt == CW'(1))           resp_byte <= sec_hi;
            else if (cnt == CW'(2))           resp_byte <= sec_lo;
            else if (cnt < CW'(BLK + 3))      load_pend <= 1'b1;
            else if (cnt == CW'(BLK + 3))     resp_byte <= chk;
            else if (cnt == CW'(BLK + 4))     resp_byte <= END_OK;
            else begin
              st        <= ST_DONE;
              resp_byte <= IDLE_BYTE;
            end
          end
          ST_WR: begin
            cnt <= cnt + 1'b1;
            if (cnt < CW'(BLK)) begin
              chk       <= chk ^ host_byte;
              resp_byte <= 8'h00;
            end else if (cnt == CW'(BLK)) begin
              resp_byte <= MK_GO;
              if (sec_hi[7:2] != 6'd0)  status_q <= END_RANGE;
              else if (chk != host_byte) status_q <= END_BADCS;
              else                       status_q <= END_OK;
            end else if (cnt == CW'(BLK + 1)) begin
              resp_byte <= MK_ACK2;
            end else if (cnt == CW'(BLK + 2)) begin
              resp_byte <= status_q;
            end else begin
              st        <= ST_DONE;
              resp_byte <= IDLE_BYTE;
              if (status_q == END_OK) fresh_q <= 1'b0;
            end
          end
          default: resp_byte <= IDLE_BYTE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mc_responder_chk.sv
module mc_responder_chk
  import mc_resp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sel,
  input logic       xfer,
  input logic [7:0] host_byte,
  input logic [7:0] resp_byte,
  input logic       ack_n,
  input logic       fresh_q,
  input state_t     st
);
  // R10
  sel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> resp_byte == IDLE_BYTE);

  // R11
  ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> $past(xfer && sel));

  // R2
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && sel && st == ST_IDLE && host_byte != ADDR_BYTE) |=> !$fell(ack_n));

  // R9
  fresh_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !fresh_q |=> !fresh_q);

  // R3
  flag_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && sel && st == ST_IDLE && host_byte == ADDR_BYTE)
      |=> resp_byte == (fresh_q ? FLAG_NEW : 8'h00));
endmodule

bind mc_responder mc_responder_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .xfer(xfer), .host_byte(host_byte),
  .resp_byte(resp_byte), .ack_n(ack_n), .fresh_q(fresh_q), .st(st)
);

// File: tb/mc_responder_bench.sv
module mc_responder_bench;
  localparam int SECTORS = 4;
  localparam int BLK     = 128;
  localparam int ACK     = 4;
  localparam int SECW    = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0;
  logic       xfer = 1'b0;
  logic [7:0] host_byte = 8'h00;
  logic [7:0] resp_byte;
  logic       ack_n;

  int checks = 0;
  int errors = 0;
  bit fresh = 1'b1;
  logic [7:0] model [SECTORS][BLK];
  logic [7:0] wbuf [BLK];

  always #4 clk = ~clk;

  mc_responder #(.SECTORS(SECTORS), .BLK(BLK), .ACK_LEN(ACK)) u_mc_responder (
    .clk(clk), .rst(rst), .sel(sel), .xfer(xfer), .host_byte(host_byte),
    .resp_byte(resp_byte), .ack_n(ack_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xchg(input logic [7:0] h, output logic [7:0] got, output int lows);
    @(negedge clk);
    got = resp_byte;
    host_byte = h;
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
    lows = (ack_n == 1'b0) ? 1 : 0;
    for (int k = 0; k < ACK + 2; k++) begin
      @(negedge clk);
      if (ack_n == 1'b0) lows++;
    end
  endtask

  task automatic fill_wbuf();
    for (int j = 0; j < BLK; j++) wbuf[j] = 8'($urandom_range(0, 255));
  endtask

  function automatic logic [7:0] flag_exp();
    return fresh ? 8'h0C : 8'h00;
  endfunction

  task automatic run_frame(input bit wr, input logic [7:0] msb, input logic [7:0] lsb,
                           input bit corrupt, input int abort_at);
    logic [7:0] hb [BLK+16];
    logic [7:0] rb [BLK+16];
    bit         ab [BLK+16];
    string      tg [BLK+16];
    logic [7:0] cs, st_exp, got;
    int last, lows, idx;
    bit aborted;
    idx = int'(lsb[SECW-1:0]);
    st_exp = 8'h00;
    for (int n = 0; n < BLK + 16; n++) begin
      hb[n] = 8'h00; rb[n] = 8'h00; ab[n] = 1'b1; tg[n] = "R5";
    end
    hb[0] = 8'h81; rb[0] = 8'hFF; tg[0] = "R2";
    hb[1] = wr ? 8'h57 : 8'h52; rb[1] = flag_exp(); tg[1] = "R9";
    hb[2] = msb; rb[2] = 8'h5A; tg[2] = "R4";
    hb[3] = lsb; rb[3] = 8'h5D; tg[3] = "R4";
    cs = msb ^ lsb;
    if (!wr) begin
      rb[4] = 8'h5C; rb[5] = 8'h5D; rb[6] = msb; rb[7] = lsb;
      for (int j = 0; j < BLK; j++) begin
        rb[8+j] = model[idx][j]; tg[8+j] = "R12"; cs ^= model[idx][j];
      end
      rb[8+BLK] = cs; tg[8+BLK] = "R6";
      rb[9+BLK] = 8'h47; ab[9+BLK] = 1'b0;
      last = 9 + BLK;
    end else begin
      for (int j = 0; j < BLK; j++) begin
        hb[4+j] = wbuf[j]; tg[4+j] = "R7"; cs ^= wbuf[j];
      end
      hb[4+BLK] = cs ^ (corrupt ? 8'h01 : 8'h00); tg[4+BLK] = "R7";
      if (msb[7:2] != 6'd0) st_exp = 8'hFF;
      else if (corrupt)     st_exp = 8'h4E;
      else                  st_exp = 8'h47;
      rb[5+BLK] = 8'h5C; tg[5+BLK] = "R7";
      rb[6+BLK] = 8'h5D; tg[6+BLK] = "R7";
      rb[7+BLK] = st_exp; tg[7+BLK] = "R8"; ab[7+BLK] = 1'b0;
      last = 7 + BLK;
    end
    @(negedge clk);
    sel = 1'b1;
    aborted = 1'b0;
    for (int n = 0; n <= last; n++) begin
      if (abort_at >= 0 && n > abort_at) begin
        aborted = 1'b1;
        break;
      end
      xchg(hb[n], got, lows);
      check(tg[n], int'(got), int'(rb[n]));
      check("R11", lows, ab[n] ? ACK : 0);
    end
    sel = 1'b0;
    @(negedge clk);
    if (aborted) check("R10", int'(resp_byte), 8'hFF);
    if (wr && !aborted && st_exp == 8'h47) begin
      for (int j = 0; j < BLK; j++) model[idx][j] = wbuf[j];
      fresh = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic bad_addr_frame();
    logic [7:0] got;
    int lows;
    @(negedge clk);
    sel = 1'b1;
    xchg(8'h82, got, lows);
    check("R2", int'(got), 8'hFF);
    check("R2", lows, 0);
    xchg(8'h81, got, lows);
    check("R2", int'(got), 8'hFF);
    check("R2", lows, 0);
    sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bad_cmd_frame();
    logic [7:0] got;
    int lows;
    @(negedge clk);
    sel = 1'b1;
    xchg(8'h81, got, lows);
    check("R2", int'(got), 8'hFF);
    check("R11", lows, ACK);
    xchg(8'h45, got, lows);
    check("R3", int'(got), int'(flag_exp()));
    check("R3", lows, 0);
    xchg(8'h00, got, lows);
    check("R3", int'(got), 8'hFF);
    check("R3", lows, 0);
    sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lsb;
    int kind;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(resp_byte), 8'hFF);
    check("R1", int'(ack_n), 1);

    fill_wbuf();
    run_frame(1'b1, 8'h00, 8'h01, 1'b1, -1);
    fill_wbuf();
    run_frame(1'b1, 8'h04, 8'h02, 1'b0, -1);
    bad_addr_frame();
    bad_cmd_frame();

    for (int s = 0; s < SECTORS; s++) begin
      fill_wbuf();
      run_frame(1'b1, 8'h00, 8'(s), 1'b0, -1);
    end
    bad_cmd_frame();
    for (int s = 0; s < SECTORS; s++) begin
      lsb = {6'($urandom_range(0, 63)), 2'(s)};
      run_frame(1'b0, 8'($urandom_range(0, 3)), lsb, 1'b0, -1);
    end

    fill_wbuf();
    run_frame(1'b1, 8'h00, 8'h02, 1'b0, 50);
    run_frame(1'b0, 8'h00, 8'h02, 1'b0, -1);
    run_frame(1'b0, 8'h01, 8'h03, 1'b0, 20);

    for (int i = 0; i < 24; i++) begin
      kind = $urandom_range(0, 4);
      lsb = 8'($urandom_range(0, 255));
      fill_wbuf();
      case (kind)
        0: run_frame(1'b0, 8'($urandom_range(0, 3)), lsb, 1'b0, -1);
        1: run_frame(1'b1, 8'($urandom_range(0, 3)), lsb, 1'b0, -1);
        2: run_frame(1'b1, 8'($urandom_range(0, 3)), lsb, 1'b1, -1);
        3: run_frame(1'b1, 8'($urandom_range(4, 255)), lsb, 1'b0, -1);
        default: run_frame(1'b1, 8'h00, lsb, 1'b0, $urandom_range(0, BLK + 6));
      endcase
    end
    run_frame(1'b0, 8'h00, 8'h00, 1'b0, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule